// File: doc/BRIEF.md
# Cluster Zero-Suppression Encoder

This block walks through one event's worth of sorted 12-bit samples held in one of two data SRAM banks. Each sample carries a 10-bit value, an above-pedestal flag and a header flag. Only runs of flagged samples survive, together with two guard bins on each side. Everything else is dropped. Each surviving run goes out as a cluster: one 16-bit header word carrying the upper address bits, then one 16-bit data word per bin. Each data word carries the three low address bits, the flag and the value. The words go to a write-only FIFO port. The encoder freezes whenever that FIFO reports full.

A small register port holds the expected sample count and a word-count threshold, and exposes the running count of words written. At the end of an event the encoder compares the number of samples it consumed with the expected count and latches a mismatch flag. A threshold output is high whenever the words written so far reach the programmed minimum. The encoder reports ready to take a new event once it has finished and the external FIFO has drained.

Top module: `zs_cluster_encoder`

## Requirements
- R1: After reset, fifo_wr is low, done is high, size_err is low, and all three readable registers return zero. ready equals fifo_empty.
- R2: A data word is {2'b01, address[2:0], above flag (sample bit 10), value (sample bits 9:0)}. A sample is flagged when bit 10 (above pedestal) or bit 11 (header) is set.
- R3: A sample at address i of an event of length N is emitted exactly when some flagged sample lies in addresses i-2..i+2 within 0..N-1. Samples are emitted in address order, and no other data words are written.
- R4: A header word {1'b1, address[17:3]} of the first bin is written only where a cluster starts, that is, when the previous sample was not emitted. No header is added when the address crosses a multiple of eight inside a cluster. Whenever the FIFO accepts, the next write after a header is the cluster's first data word.
- R5: The first header of an event is followed by the event number latched at start, then by 16'h0000, and only then by the cluster's data words.
- R6: Reads go only to the bank chosen by bank_odd at the accepted start (rd_odd for 1, rd_even for 0). The address counts up from 0 to scan_len-1.
- R7: fifo_wr is never high while fifo_full is high. Stalls do not change the emitted word sequence.
- R8: Register select 0 is the expected size (read/write) and select 1 is the threshold (read/write). Select 2 returns the running write count, and writes to it are ignored. Select 3 reads zero and ignores writes.
- R9: The running count is readable mid-event, equals the number of words written since the accepted start, and clears at each accepted start.
- R10: When an event finishes, size_err is set exactly when the number of samples consumed differs from the expected size. It stays unchanged until the next accepted start clears it.
- R11: thresh is high exactly when the running count is at least the threshold register.
- R12: done falls on an accepted start and rises when the last sample has been handled. ready is done AND fifo_empty.
- R13: A start pulse while an event is in progress is ignored. It changes neither the bank, the stream nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an event when idle |
| bank_odd | input | 1 | Bank select captured at start (1 = odd bank) |
| scan_len | input | CNT_W | Number of samples in the event |
| evt_num | input | 16 | Event number for the first cluster |
| sram_addr | output | ADDR_W | Read address for both banks |
| rd_even | output | 1 | Read strobe for the even bank |
| rd_odd | output | 1 | Read strobe for the odd bank |
| even_rdata | input | 12 | Even bank data, one cycle after the strobe |
| odd_rdata | input | 12 | Odd bank data, one cycle after the strobe |
| fifo_full | input | 1 | Output FIFO cannot accept a word |
| fifo_empty | input | 1 | Output FIFO holds no words |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_wdata | output | 16 | Word written to the FIFO |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Register write value |
| reg_rdata | output | CNT_W | Register read value (combinational) |
| done | output | 1 | Event processing complete |
| ready | output | 1 | Done and FIFO drained |
| size_err | output | 1 | Consumed sample count differed from expected |
| thresh | output | 1 | Running count reached the threshold |

## Verification
The bench builds the encoder with ADDR_W=18 and a narrow CNT_W=12. Events of a few hundred samples then cover runs that merge, runs that cross an 8-address boundary, a run cut short at the end of the event, an all-quiet event and an empty event. The full 18-bit address width keeps the header's upper-address field at its real position. A pseudo-random FIFO-full pattern stalls header, extra and data cycles alike. A start pulse and a write to the count register are injected in the middle of a busy event.

// File: rtl/zs_cluster_encoder.sv
module zs_cluster_encoder #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bank_odd,
  input  logic [CNT_W-1:0]  scan_len,
  input  logic [15:0]       evt_num,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              rd_even,
  output logic              rd_odd,
  input  logic [11:0]       even_rdata,
  input  logic [11:0]       odd_rdata,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic              fifo_wr,
  output logic [15:0]       fifo_wdata,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              done,
  output logic              ready,
  output logic              size_err,
  output logic              thresh
);

  localparam int HA_W = 18;

  function automatic logic flagged(input logic [11:0] w);
    return w[10] | w[11];
  endfunction

  logic              running, done_q, err_q, bank_q, rd_v, in_clu, first_q;
  logic [CNT_W-1:0]  len_q, fetch_cnt, cons_cnt, wcount, exp_q, thr_q;
  logic [15:0]       evn_q;
  logic [1:0]        qcnt, sub, hist;
  logic [11:0]       q0, q1;
  logic [2:0]        sv;
  logic [11:0]       sd [3];
  logic [ADDR_W-1:0] sa [3];

  logic [11:0]  rdata, in_word;
  logic [4:0]   win;
  logic [2:0]   occ;
  logic [HA_W-1:0] ca;
  logic fetch_more, in_v, have_in, kept, hdr_cyc, adv, data_wr, pop, issue, finish;

  assign rdata      = bank_q ? odd_rdata : even_rdata;
  assign fetch_more = running && (fetch_cnt != len_q);
  assign in_v       = (qcnt != 2'd0);
  assign in_word    = in_v ? q0 : 12'd0;
  assign have_in    = in_v || (!fetch_more && !rd_v);
  assign win        = {hist, sv[2] & flagged(sd[2]), sv[1] & flagged(sd[1]), sv[0] & flagged(sd[0])};
  assign kept       = sv[2] && (|win);
  assign hdr_cyc    = running && !fifo_full && kept && (!in_clu || sub != 2'd0);
  assign adv        = running && !fifo_full && have_in && !hdr_cyc;
  assign data_wr    = adv && kept;
  assign pop        = adv && in_v;
  assign occ        = {1'b0, qcnt} + {2'b0, rd_v} - {2'b0, pop};
  assign issue      = fetch_more && (occ <= 3'd1);
  assign finish     = running && !fetch_more && !rd_v && !in_v && (sv == 3'b000);

  assign sram_addr  = ADDR_W'(fetch_cnt);
  assign rd_even    = issue && !bank_q;
  assign rd_odd     = issue && bank_q;
  assign fifo_wr    = hdr_cyc || data_wr;
  assign ca         = HA_W'(sa[2]);

  always_comb begin
    fifo_wdata = {2'b01, ca[2:0], sd[2][10], sd[2][9:0]};
    if (hdr_cyc) begin
      case (sub)
        2'd0:    fifo_wdata = {1'b1, ca[HA_W-1:3]};
        2'd1:    fifo_wdata = evn_q;
        default: fifo_wdata = 16'h0000;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = exp_q;
      2'd1:    reg_rdata = thr_q;
      2'd2:    reg_rdata = wcount;
      default: reg_rdata = '0;
    endcase
  end

  assign done     = done_q;
  assign ready    = done_q && fifo_empty;
  assign size_err = err_q;
  assign thresh   = (wcount >= thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; done_q <= 1'b1; err_q <= 1'b0; bank_q <= 1'b0;
      rd_v <= 1'b0; in_clu <= 1'b0; first_q <= 1'b0;
      len_q <= '0; fetch_cnt <= '0; cons_cnt <= '0; wcount <= '0;
      exp_q <= '0; thr_q <= '0; evn_q <= '0;
      qcnt <= '0; sub <= '0; hist <= '0; q0 <= '0; q1 <= '0; sv <= '0;
      for (int i = 0; i < 3; i++) begin
        sd[i] <= '0;
        sa[i] <= '0;
      end
    end else begin
      if (reg_wr && reg_sel == 2'd0) exp_q <= reg_wdata;
      if (reg_wr && reg_sel == 2'd1) thr_q <= reg_wdata;
      if (start && !running) begin
        running <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
        bank_q <= bank_odd; len_q <= scan_len; evn_q <= evt_num;
        fetch_cnt <= '0; cons_cnt <= '0; wcount <= '0;
        rd_v <= 1'b0; qcnt <= '0; sv <= '0; hist <= '0;
        in_clu <= 1'b0; first_q <= 1'b1; sub <= '0;
      end else if (running) begin
        fetch_cnt <= fetch_cnt + CNT_W'(issue);
        rd_v      <= issue;
        wcount    <= wcount + CNT_W'(fifo_wr);
        case ({rd_v, pop})
          2'b10: begin
            if (qcnt == 2'd0) q0 <= rdata;
            else              q1 <= rdata;
            qcnt <= qcnt + 2'd1;
          end
          2'b01: begin
            q0   <= q1;
            qcnt <= qcnt - 2'd1;
          end
          2'b11: begin
            if (qcnt == 2'd1) q0 <= rdata;
            else begin
              q0 <= q1;
              q1 <= rdata;
            end
          end
          default: ;
        endcase
        if (adv) begin
          sd[0] <= in_word; sa[0] <= ADDR_W'(cons_cnt); sv[0] <= in_v;
          sd[1] <= sd[0];   sa[1] <= sa[0];             sv[1] <= sv[0];
          sd[2] <= sd[1];   sa[2] <= sa[1];             sv[2] <= sv[1];
          hist     <= {hist[0], win[2]};
          cons_cnt <= cons_cnt + CNT_W'(in_v);
          if (sv[2] && !kept) in_clu <= 1'b0;
        end
        if (hdr_cyc) begin
          case (sub)
            2'd0: begin
              in_clu  <= 1'b1;
              first_q <= 1'b0;
              sub     <= first_q ? 2'd1 : 2'd0;
            end
            2'd1:    sub <= 2'd2;
            default: sub <= 2'd0;
          endcase
        end
        if (finish) begin
          running <= 1'b0;
          done_q  <= 1'b1;
          err_q   <= (cons_cnt != exp_q);
        end
      end
    end
  end

  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= 2'd2);

  assert_read_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_even || rd_odd) |-> (running && $onehot0({rd_even, rd_odd})));

  assert_data_follows_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_cyc && sub == 2'd0 && !first_q) |=> (!fifo_wr || fifo_wdata[15:14] == 2'b01));

  assert_err_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !running);

  assert_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !finish) |=> running);

  assert_no_write_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !fifo_wr);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fifo_wr) |=> $stable(wcount));

endmodule

// File: tb/zs_cluster_encoder_tb_top.sv
module zs_cluster_encoder_tb_top;
  localparam int AW = 18;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bank_odd = 1'b0;
  logic [CW-1:0] scan_len = '0;
  logic [15:0] evt_num = '0;
  logic [AW-1:0] sram_addr;
  logic rd_even, rd_odd;
  logic [11:0] even_rdata = '0, odd_rdata = '0;
  logic fifo_full = 1'b0, fifo_empty = 1'b1;
  logic fifo_wr;
  logic [15:0] fifo_wdata;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic done, ready, size_err, thresh;

  always #5 clk = ~clk;

  zs_cluster_encoder #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_odd(bank_odd),
    .scan_len(scan_len), .evt_num(evt_num), .sram_addr(sram_addr),
    .rd_even(rd_even), .rd_odd(rd_odd), .even_rdata(even_rdata),
    .odd_rdata(odd_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done(done), .ready(ready), .size_err(size_err), .thresh(thresh));

  logic [11:0] mem_e [0:511];
  logic [11:0] mem_o [0:511];
  logic [15:0] expq [$];
  int n_chk = 0, n_fail = 0;
  int model_cnt = 0, thr_v = 0;
  bit cur_odd = 1'b0, mon_on = 1'b0, stall_en = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    if (rd_even) even_rdata <= mem_e[sram_addr[8:0]];
    if (rd_odd)  odd_rdata  <= mem_o[sram_addr[8:0]];
  end

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fifo_full = stall_en && lfsr[0] && lfsr[3];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      check(thresh == (model_cnt >= thr_v), "R11", "thresh", int'(thresh), int'(model_cnt >= thr_v));
      check(!(rd_odd && !cur_odd) && !(rd_even && cur_odd), "R6", "bank strobe",
            int'({rd_odd, rd_even}), int'(cur_odd));
      if (fifo_wr) begin
        check(!fifo_full, "R7", "write while full", 1, 0);
        if (expq.size() == 0) check(1'b0, "R3", "unexpected word", int'(fifo_wdata), 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(fifo_wdata == e, "R2/R4/R5", "stream word", int'(fifo_wdata), int'(e));
        end
        model_cnt++;
      end
    end
  end

  task automatic fill(input bit odd, input int hdrs, input int dens, input logic [31:0] seed);
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < 512; i++) begin
      logic [11:0] w;
      s = s * 32'd1103515245 + 32'd12345;
      w = {2'b00, s[17:8]};
      if (i < hdrs) w = {2'b10, 10'(i)};
      else if (dens > 0 && (s[27:20] % dens) == 0) w[10] = 1'b1;
      if (odd) mem_o[i] = w; else mem_e[i] = w;
    end
  endtask

  task automatic build_exp(input bit odd, input int len, input logic [15:0] evn);
    bit mk [0:511];
    bit prev, first;
    prev = 1'b0; first = 1'b1;
    for (int i = 0; i < len; i++) begin
      logic [11:0] w;
      w = odd ? mem_o[i] : mem_e[i];
      mk[i] = w[10] | w[11];
    end
    for (int i = 0; i < len; i++) begin
      bit kp;
      logic [11:0] w;
      logic [17:0] a;
      kp = 1'b0;
      for (int d = -2; d <= 2; d++)
        if (i + d >= 0 && i + d < len && mk[i+d]) kp = 1'b1;
      w = odd ? mem_o[i] : mem_e[i];
      a = 18'(i);
      if (kp) begin
        if (!prev) begin
          expq.push_back({1'b1, a[17:3]});
          if (first) begin
            expq.push_back(evn);
            expq.push_back(16'h0000);
            first = 1'b0;
          end
        end
        expq.push_back({2'b01, a[2:0], w[10], w[9:0]});
      end
      prev = kp;
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input int val);
    @(posedge clk); #2;
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = CW'(val);
    @(posedge clk); #2;
    reg_wr = 1'b0;
    if (sel == 2'd1) thr_v = val;
  endtask

  task automatic reg_read(input logic [1:0] sel, output int val);
    @(posedge clk); #2;
    reg_sel = sel;
    #1 val = int'(reg_rdata);
  endtask

  task automatic run_event(input bit odd, input int len, input logic [15:0] evn,
                           input int exp_sz, input int poke_at);
    int rv, cyc;
    build_exp(odd, len, evn);
    @(posedge clk); #2;
    start = 1'b1; bank_odd = odd; scan_len = CW'(len); evt_num = evn;
    @(posedge clk); #2;
    start = 1'b0; model_cnt = 0; cur_odd = odd;
    check(!done, "R12", "done low after start", int'(done), 0);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (poke_at > 0 && cyc == poke_at) begin
        check(!ready, "R12", "ready low while busy", int'(ready), 0);
        @(posedge clk); #2;
        start = 1'b1; bank_odd = !odd; evt_num = 16'hDEAD;
        @(posedge clk); #2;
        start = 1'b0;
        reg_write(2'd2, 0);
        reg_read(2'd2, rv);
        check(rv == model_cnt, "R9/R8/R13", "mid-event count", rv, model_cnt);
        check(model_cnt > 0, "R13", "count not cleared by start", model_cnt, 1);
      end
    end
    check(expq.size() == 0, "R3", "words left unemitted", expq.size(), 0);
    check(size_err == (len != exp_sz), "R10", "size error", int'(size_err), int'(len != exp_sz));
    reg_read(2'd2, rv);
    check(rv == model_cnt, "R9", "final count", rv, model_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R12", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rv;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b1, "R1", "done after reset", int'(done), 1);
    check(!fifo_wr, "R1", "no write after reset", int'(fifo_wr), 0);
    check(!size_err, "R1", "size_err after reset", int'(size_err), 0);
    check(ready == fifo_empty, "R1", "ready after reset", int'(ready), int'(fifo_empty));
    for (int s = 0; s < 3; s++) begin
      reg_read(2'(s), rv);
      check(rv == 0, "R1", "register after reset", rv, 0);
    end
    mon_on = 1'b1;

    reg_write(2'd0, 80);
    reg_write(2'd1, 40);
    reg_write(2'd3, 55);
    reg_read(2'd0, rv); check(rv == 80, "R8", "expected size readback", rv, 80);
    reg_read(2'd1, rv); check(rv == 40, "R8", "threshold readback", rv, 40);
    reg_read(2'd3, rv); check(rv == 0, "R8", "select 3 reads zero", rv, 0);

    fill(1'b0, 32, 0, 32'h1234);
    for (int i = 40; i <= 44; i++) mem_e[i][10] = 1'b1;
    mem_e[60][10] = 1'b1; mem_e[64][10] = 1'b1; mem_e[67][10] = 1'b1; mem_e[79][10] = 1'b1;
    run_event(1'b0, 80, 16'hA5C3, 80, 0);
    check(thresh == (model_cnt >= 40), "R11", "thresh after event", int'(thresh), int'(model_cnt >= 40));

    fifo_empty = 1'b0;
    @(negedge clk);
    check(!ready, "R12", "ready needs empty fifo", int'(ready), 0);
    fifo_empty = 1'b1;
    @(negedge clk);
    check(ready, "R12", "ready when done and empty", int'(ready), 1);

    stall_en = 1'b1;
    reg_write(2'd0, 300);
    reg_write(2'd1, 90);
    fill(1'b1, 32, 7, 32'hBEEF);
    run_event(1'b1, 301, 16'h3C5A, 300, 120);

    reg_write(2'd1, 3);
    fill(1'b0, 0, 0, 32'h777);
    run_event(1'b0, 50, 16'h0101, 300, 0);
    check(model_cnt == 0, "R3", "quiet event writes nothing", model_cnt, 0);
    check(!thresh, "R11", "thresh low below minimum", int'(thresh), 0);

    reg_write(2'd0, 0);
    run_event(1'b1, 0, 16'h0202, 0, 0);
    check(done, "R12", "empty event completes", int'(done), 1);

    fill(1'b0, 32, 3, 32'h5151);
    reg_write(2'd0, 200);
    run_event(1'b0, 200, 16'hFACE, 200, 0);
    stall_en = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule